// File: doc/BRIEF.md
# Streaming Multiply-Add Processing Element

This block takes a stream of beats, each holding three signed operands, and returns a stream of signed results. Each result is the product of the first two operands plus the third. The arithmetic is combinational. The handshake is passed straight across the block, so a result leaves on the output stream in the same cycle that its operands are taken from the input stream. Back-pressure from the consumer reaches the producer within that cycle. No beat is ever held inside the block.

An enable input gates all traffic. While it is low, the block takes no input and offers no output. The active-low reset clears the block asynchronously. Release of the reset passes through a short synchronizer before the handshake opens. The block is meant to sit between a stream producer, such as a memory-to-stream mover, and a stream consumer.

Top module: `stream_mac_pe`

## Requirements
- R1: When an output beat is valid, its data is the two's complement value a*b + c, taken at RES_W bits. All operands are signed. With the defaults (16-bit operands, 32-bit result) the value is always exact.
- R2: Operand fields in the input data are placed as follows: a in bits [OP_W-1:0], b in bits [2*OP_W-1:OP_W], c in bits [3*OP_W-1:2*OP_W].
- R3: Latency is zero. The output data and flags follow the input in the same cycle, with no clock edge in between.
- R4: While enabled and out of reset, output valid equals input valid.
- R5: While enabled and out of reset, input ready equals output ready.
- R6: The last-of-packet flag of an output beat equals the flag of the input beat it came from.
- R7: While enable is low, output valid and input ready are both low, whatever valid and ready the neighbours present.
- R8: While the reset input is low, output valid and input ready are low at once, with no clock edge needed.
- R9: After the reset input rises, valid and ready stay low through the first SYNC_STAGES-1 rising clock edges. They follow the neighbours from the SYNC_STAGES-th edge onward (the 2nd edge by default).
- R10: Under random input gaps and output stalls, every accepted input beat appears exactly once on the output, in order. A beat is accepted on the input in exactly the cycle its result is accepted on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Gates both handshakes |
| s_axis_tdata | input | 3*OP_W | Packed operands {c, b, a} |
| s_axis_tvalid | input | 1 | Input beat valid |
| s_axis_tready | output | 1 | Input beat may be taken |
| s_axis_tlast | input | 1 | Input beat ends a packet |
| m_axis_tdata | output | RES_W | Result a*b + c |
| m_axis_tvalid | output | 1 | Output beat valid |
| m_axis_tready | input | 1 | Consumer takes the beat |
| m_axis_tlast | output | 1 | Output beat ends a packet |

## Verification
The bench builds the block with its defaults: 16-bit operands, a 32-bit result and a two-stage reset synchronizer. With these widths the extreme operands can be applied directly. The most negative value squared, and the most negative times the most positive, drive the result to the edges of its range, where a mistake in a field slice or in sign extension changes the value. Two synchronizer stages make the release delay long enough to observe: the handshake is shown to stay closed after the first edge and to open after the second.

// File: rtl/pe_pkg.sv
package pe_pkg;
  // Default widths shared by the block and its checker
  parameter int unsigned PE_OP_W    = 16;
  parameter int unsigned PE_RES_W   = 32;
  parameter int unsigned PE_SYNC_N  = 2;
  parameter int unsigned PE_N_OPS   = 3;

  // Field order inside the input beat
  typedef enum logic [1:0] {
    FLD_MCAND = 2'd0,
    FLD_MPLR  = 2'd1,
    FLD_ADDND = 2'd2
  } pe_field_e;
endpackage

// File: rtl/pe_rst_sync.sv
module pe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign run = sync_q[STAGES-1];
endmodule

// File: rtl/pe_operand_split.sv
module pe_operand_split
  import pe_pkg::*;
#(
  parameter int unsigned OP_W = PE_OP_W
) (
  input  logic [PE_N_OPS*OP_W-1:0]    beat,
  output logic [PE_N_OPS-1:0][OP_W-1:0] ops
);
  generate
    for (genvar i = 0; i < PE_N_OPS; i++) begin : g_fld
      assign ops[i] = beat[i*OP_W +: OP_W];
    end
  endgenerate
endmodule

// File: rtl/pe_mac_core.sv
module pe_mac_core #(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned RES_W = 32
) (
  input  logic signed [OP_W-1:0]  mcand,
  input  logic signed [OP_W-1:0]  mplr,
  input  logic signed [OP_W-1:0]  addnd,
  output logic        [RES_W-1:0] result
);
  localparam int unsigned PROD_W = 2 * OP_W;
  localparam int unsigned SUM_W  = PROD_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  sum;

  always_comb begin
    prod = PROD_W'(mcand) * PROD_W'(mplr);
    sum  = SUM_W'(prod) + SUM_W'(addnd);
  end

  generate
    if (RES_W > SUM_W) begin : g_ext
      assign result = {{(RES_W-SUM_W){sum[SUM_W-1]}}, sum};
    end else if (RES_W == SUM_W) begin : g_eq
      assign result = sum;
    end else begin : g_trunc
      assign result = sum[RES_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pe_stream_gate.sv
module pe_stream_gate (
  input  logic enable,
  input  logic run,
  input  logic up_valid,
  input  logic up_last,
  input  logic dn_ready,
  output logic up_ready,
  output logic dn_valid,
  output logic dn_last
);
  logic pass;

  always_comb begin
    pass     = enable & run;
    dn_valid = up_valid & pass;
    up_ready = dn_ready & pass;
    dn_last  = up_last;
  end
endmodule

// File: rtl/stream_mac_pe.sv
module stream_mac_pe
  import pe_pkg::*;
#(
  parameter int unsigned OP_W        = PE_OP_W,
  parameter int unsigned RES_W       = PE_RES_W,
  parameter int unsigned SYNC_STAGES = PE_SYNC_N
) (
  input  logic                       aclk,
  input  logic                       aresetn,
  input  logic                       enable,
  input  logic [PE_N_OPS*OP_W-1:0]   s_axis_tdata,
  input  logic                       s_axis_tvalid,
  output logic                       s_axis_tready,
  input  logic                       s_axis_tlast,
  output logic [RES_W-1:0]           m_axis_tdata,
  output logic                       m_axis_tvalid,
  input  logic                       m_axis_tready,
  output logic                       m_axis_tlast
);
  logic                           run;
  logic [PE_N_OPS-1:0][OP_W-1:0]  ops;

  pe_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (aclk),
    .rst_n (aresetn),
    .run   (run)
  );

  pe_operand_split #(.OP_W(OP_W)) u_split (
    .beat (s_axis_tdata),
    .ops  (ops)
  );

  pe_mac_core #(.OP_W(OP_W), .RES_W(RES_W)) u_core (
    .mcand  (ops[FLD_MCAND]),
    .mplr   (ops[FLD_MPLR]),
    .addnd  (ops[FLD_ADDND]),
    .result (m_axis_tdata)
  );

  pe_stream_gate u_gate (
    .enable   (enable),
    .run      (run),
    .up_valid (s_axis_tvalid),
    .up_last  (s_axis_tlast),
    .dn_ready (m_axis_tready),
    .up_ready (s_axis_tready),
    .dn_valid (m_axis_tvalid),
    .dn_last  (m_axis_tlast)
  );
endmodule

// File: rtl/stream_mac_pe_chk.sv
module stream_mac_pe_chk #(
  parameter int unsigned OP_W  = 16,
  parameter int unsigned RES_W = 32
) (
  input logic                 aclk,
  input logic                 aresetn,
  input logic                 enable,
  input logic [3*OP_W-1:0]    s_axis_tdata,
  input logic                 s_axis_tvalid,
  input logic                 s_axis_tready,
  input logic                 s_axis_tlast,
  input logic [RES_W-1:0]     m_axis_tdata,
  input logic                 m_axis_tvalid,
  input logic                 m_axis_tready,
  input logic                 m_axis_tlast
);
  logic signed [63:0] model;

  always_comb begin
    model = 64'($signed(s_axis_tdata[OP_W-1:0])) * 64'($signed(s_axis_tdata[2*OP_W-1:OP_W]))
          + 64'($signed(s_axis_tdata[3*OP_W-1:2*OP_W]));
  end

  // R1
  result_value_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    m_axis_tvalid |-> (m_axis_tdata == model[RES_W-1:0]));

  // R4
  valid_source_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    m_axis_tvalid |-> s_axis_tvalid);

  // R5
  ready_source_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    s_axis_tready |-> m_axis_tready);

  // R6
  last_follow_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    m_axis_tvalid |-> (m_axis_tlast == s_axis_tlast));

  // R7
  gated_idle_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    !enable |-> (!m_axis_tvalid && !s_axis_tready));

  // R9
  release_hold_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    $rose(aresetn) |-> (!m_axis_tvalid && !s_axis_tready));

  // R10
  paired_xfer_chk: assert property (@(posedge aclk) disable iff (!aresetn)
    (s_axis_tvalid && s_axis_tready) |-> (m_axis_tvalid && m_axis_tready));
endmodule

bind stream_mac_pe stream_mac_pe_chk #(.OP_W(OP_W), .RES_W(RES_W)) u_chk (
  .aclk          (aclk),
  .aresetn       (aresetn),
  .enable        (enable),
  .s_axis_tdata  (s_axis_tdata),
  .s_axis_tvalid (s_axis_tvalid),
  .s_axis_tready (s_axis_tready),
  .s_axis_tlast  (s_axis_tlast),
  .m_axis_tdata  (m_axis_tdata),
  .m_axis_tvalid (m_axis_tvalid),
  .m_axis_tready (m_axis_tready),
  .m_axis_tlast  (m_axis_tlast)
);

// File: tb/stream_mac_pe_test.sv
`timescale 1ns/1ps
module stream_mac_pe_test;
  localparam int OP_W  = 16;
  localparam int RES_W = 32;
  localparam int NVEC  = 8;
  localparam int TOTAL = 200;

  localparam int TA [NVEC] = '{3, -3, 0, 32767, -32768, -32768, 100, -1};
  localparam int TB [NVEC] = '{4, 4, 1234, 32767, -32768, 32767, -100, -1};
  localparam int TC [NVEC] = '{5, 5, -1, 0, 32767, -32768, 10000, -32768};
  localparam int TE [NVEC] = '{17, -7, -1, 1073676289, 1073774591, -1073741824, 0, -32767};
  localparam bit TL [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1};

  logic             aclk = 1'b0;
  logic             aresetn;
  logic             enable;
  logic [3*OP_W-1:0] s_axis_tdata;
  logic             s_axis_tvalid;
  logic             s_axis_tready;
  logic             s_axis_tlast;
  logic [RES_W-1:0] m_axis_tdata;
  logic             m_axis_tvalid;
  logic             m_axis_tready;
  logic             m_axis_tlast;

  int checks = 0;
  int errors = 0;

  always #2.5 aclk = ~aclk;

  stream_mac_pe uut (
    .aclk(aclk), .aresetn(aresetn), .enable(enable),
    .s_axis_tdata(s_axis_tdata), .s_axis_tvalid(s_axis_tvalid),
    .s_axis_tready(s_axis_tready), .s_axis_tlast(s_axis_tlast),
    .m_axis_tdata(m_axis_tdata), .m_axis_tvalid(m_axis_tvalid),
    .m_axis_tready(m_axis_tready), .m_axis_tlast(m_axis_tlast)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3*OP_W-1:0] pack(input int a, input int b, input int c);
    return {16'(c), 16'(b), 16'(a)};
  endfunction

  function automatic logic [RES_W-1:0] ref_mac(input int a, input int b, input int c);
    longint r;
    r = longint'(a) * longint'(b) + longint'(c);
    return r[RES_W-1:0];
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int ea [TOTAL];
    int eb [TOTAL];
    int ec [TOTAL];
    bit el [TOTAL];
    int idx;
    int outs;
    int remain;
    aresetn = 1'b0; enable = 1'b1; s_axis_tvalid = 1'b1; m_axis_tready = 1'b1;
    s_axis_tlast = 1'b1; s_axis_tdata = pack(1, 1, 1);
    #1;
    // R8: reset state
    check(!m_axis_tvalid && !s_axis_tready, "R8 reset state", {m_axis_tvalid, s_axis_tready}, 0);
    repeat (3) @(negedge aclk);
    aresetn = 1'b1;
    repeat (3) @(negedge aclk);

    // Vector table: R1, R2, R3, R6
    for (int i = 0; i < NVEC; i++) begin
      @(negedge aclk);
      s_axis_tdata = pack(TA[i], TB[i], TC[i]);
      s_axis_tlast = TL[i];
      s_axis_tvalid = 1'b1; m_axis_tready = 1'b1;
      #1;
      check(m_axis_tdata == 32'(TE[i]), "R1 R2 R3 result", m_axis_tdata, 32'(TE[i]));
      check(m_axis_tlast == TL[i], "R6 last", m_axis_tlast, TL[i]);
      check(m_axis_tvalid && s_axis_tready, "R4 R5 handshake", {m_axis_tvalid, s_axis_tready}, 3);
    end

    // R2: single field set at a time
    @(negedge aclk);
    s_axis_tdata = pack(0, 0, 77); #1;
    check(m_axis_tdata == 32'd77, "R2 addend field", m_axis_tdata, 77);
    s_axis_tdata = pack(7, 1, 0); #1;
    check(m_axis_tdata == 32'd7, "R2 low fields", m_axis_tdata, 7);

    // R4, R5: independent valid and ready
    s_axis_tvalid = 1'b0; m_axis_tready = 1'b1; #1;
    check(!m_axis_tvalid && s_axis_tready, "R4 R5 no valid", {m_axis_tvalid, s_axis_tready}, 1);
    s_axis_tvalid = 1'b1; m_axis_tready = 1'b0; #1;
    check(m_axis_tvalid && !s_axis_tready, "R4 R5 stall", {m_axis_tvalid, s_axis_tready}, 2);

    // R7: enable low blocks both directions
    @(negedge aclk);
    enable = 1'b0; s_axis_tvalid = 1'b1; m_axis_tready = 1'b1; #1;
    check(!m_axis_tvalid && !s_axis_tready, "R7 disabled", {m_axis_tvalid, s_axis_tready}, 0);
    @(negedge aclk); #1;
    check(!m_axis_tvalid && !s_axis_tready, "R7 disabled held", {m_axis_tvalid, s_axis_tready}, 0);
    @(negedge aclk);
    enable = 1'b1; #1;
    check(m_axis_tvalid && s_axis_tready, "R7 re-enabled", {m_axis_tvalid, s_axis_tready}, 3);

    // R8 and R9: asynchronous assert, synchronized release
    @(negedge aclk);
    aresetn = 1'b0; #1;
    check(!m_axis_tvalid && !s_axis_tready, "R8 async clear", {m_axis_tvalid, s_axis_tready}, 0);
    @(negedge aclk);
    aresetn = 1'b1; #1;
    check(!m_axis_tvalid && !s_axis_tready, "R9 before edge", {m_axis_tvalid, s_axis_tready}, 0);
    @(negedge aclk); #1;
    check(!m_axis_tvalid && !s_axis_tready, "R9 after first edge", {m_axis_tvalid, s_axis_tready}, 0);
    @(negedge aclk); #1;
    check(m_axis_tvalid && s_axis_tready, "R9 after second edge", {m_axis_tvalid, s_axis_tready}, 3);

    // R10: random packets, gaps and stalls
    remain = 0;
    for (int k = 0; k < TOTAL; k++) begin
      ea[k] = int'($urandom_range(0, 65535)) - 32768;
      eb[k] = int'($urandom_range(0, 65535)) - 32768;
      ec[k] = int'($urandom_range(0, 65535)) - 32768;
      if (remain == 0) remain = int'($urandom_range(1, 8));
      remain--;
      el[k] = (remain == 0) || (k == TOTAL - 1);
    end
    idx = 0; outs = 0;
    s_axis_tvalid = 1'b0;
    while (idx < TOTAL) begin
      @(negedge aclk);
      if (!s_axis_tvalid) s_axis_tvalid = ($urandom_range(0, 3) != 0);
      s_axis_tdata = pack(ea[idx], eb[idx], ec[idx]);
      s_axis_tlast = el[idx];
      m_axis_tready = ($urandom_range(0, 9) < 7);
      #1;
      if (m_axis_tvalid && m_axis_tready) begin
        outs++;
        check(m_axis_tdata == ref_mac(ea[idx], eb[idx], ec[idx]), "R10 R1 data",
              m_axis_tdata, ref_mac(ea[idx], eb[idx], ec[idx]));
        check(m_axis_tlast == el[idx], "R10 R6 last", m_axis_tlast, el[idx]);
      end
      check((s_axis_tvalid && s_axis_tready) == (m_axis_tvalid && m_axis_tready),
            "R10 paired transfer", {s_axis_tvalid && s_axis_tready, m_axis_tvalid && m_axis_tready},
            {s_axis_tvalid && s_axis_tready, s_axis_tvalid && s_axis_tready});
      if (s_axis_tvalid && s_axis_tready) begin
        idx++;
        s_axis_tvalid = 1'b0;
      end
    end
    check(outs == TOTAL, "R10 beat count", outs, TOTAL);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule